// File: doc/BRIEF.md
# UART Interrupt Prioritiser and Identifier

This block is the interrupt front end of one serial channel. It takes four request conditions from the surrounding channel logic: a line status error, received data or a receive timeout, a transmit holding register that has gone empty, and a modem status change. Each passes through its own bit of a 4-bit enable register. The block drives one active-high interrupt line. It also builds an 8-bit identification code that software reads to learn which enabled source has the highest priority.

The transmit-empty condition is the only request the block holds itself. It is latched when the gated empty condition rises. It is dropped when software writes the holding register, or when software reads the identification code while transmit-empty is the source that code reports. The other three sources are level conditions that the channel keeps until their own clear actions. A FIFO-mode flag adds the receive timeout to the receive group and changes the fixed top bits of the code.

Top module: `uart_irq_ident`

## Requirements
- R1: Enable bit 0 gates the receive group, bit 1 the transmit-empty request, bit 2 line status and bit 3 modem status. A disabled source does not reach `irq_o` or `ident_o`, so with all four bits clear `irq_o` stays low.
- R2: `irq_o` is active high and is 1 exactly when at least one enabled source is pending.
- R3: `ident_o[0]` is 0 while an interrupt is pending and 1 when none is pending. In that idle case `ident_o[3:1]` is 000.
- R4: `ident_o[2:1]` names the highest pending source. The order runs line status (11), then receive group (10), then transmit-empty (01), then modem status (00).
- R5: In FIFO mode a receive timeout alone reports the receive group with `ident_o[3]` = 1. When received data is also present, `ident_o[3]` is 0. Outside FIFO mode the timeout input has no effect and `ident_o[3]` is always 0.
- R6: `ident_o[7:6]` reads 11 in FIFO mode and 00 otherwise. `ident_o[5:4]` is always 00.
- R7: The transmit-empty request is set at the clock edge after the AND of `tx_empty_i` and enable bit 1 rises. A rise caused by setting the enable while the buffer is already empty also counts.
- R8: A `hold_wr_i` pulse clears the transmit-empty request at that clock edge. This clear wins over a new set in the same cycle.
- R9: An `ident_rd_i` pulse clears the transmit-empty request only when `ident_o[2:1]` reads 01 during that read. A read while another source is reported leaves the request in place.
- R10: While `rst` is high the transmit-empty request is cleared. With no source active, `ident_o` then reads 8'h01 and `irq_o` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst | input | 1 | Synchronous reset, active high |
| line_err_i | input | 1 | Line status error condition |
| rx_avail_i | input | 1 | Received data available condition |
| rx_timeout_i | input | 1 | Receive character timeout condition (FIFO mode) |
| tx_empty_i | input | 1 | Transmit holding register empty condition |
| modem_chg_i | input | 1 | Modem status change condition |
| irq_en_i | input | 4 | Per-source enables: 0 receive, 1 transmit-empty, 2 line, 3 modem |
| fifo_mode_i | input | 1 | FIFO mode selected |
| ident_rd_i | input | 1 | One-cycle strobe: identification code read |
| hold_wr_i | input | 1 | One-cycle strobe: transmit holding register write |
| irq_o | output | 1 | Interrupt request, active high |
| ident_o | output | 8 | Identification code |

## Verification
The checker assumes that `ident_rd_i` and `hold_wr_i` are single-cycle strobes sampled on the rising clock edge. It also assumes that every input has a defined level while `rst` is held. The read-clear property adds one condition: `tx_empty_i` and enable bit 1 must not change in the cycle of the read. The bench holds these assumptions by driving all inputs on the falling edge and giving each strobe exactly one clock. It also keeps the transmit-empty condition and its enable steady around every read it issues.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NUM_SRC  = 4;
    localparam int ID_W     = 2;
    localparam int IDENT_W  = 8;

    // enable / raw-source bit positions (software-visible enable layout)
    localparam int EN_RX    = 0;
    localparam int EN_TXE   = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

    typedef enum logic [ID_W-1:0] {
        ID_MODEM = 2'b00,
        ID_TXE   = 2'b01,
        ID_RXD   = 2'b10,
        ID_LINE  = 2'b11
    } irq_id_e;

    typedef struct packed {
        logic [1:0] fifo_tag;
        logic [1:0] rsvd;
        logic       timeout;
        irq_id_e    id;
        logic       idle;
    } ident_t;

    // Highest-priority pick over the gated source vector.
    function automatic irq_id_e pick_id(input logic [NUM_SRC-1:0] g);
        irq_id_e r;
        if (g[EN_LINE])       r = ID_LINE;
        else if (g[EN_RX])    r = ID_RXD;
        else if (g[EN_TXE])   r = ID_TXE;
        else                  r = ID_MODEM;
        return r;
    endfunction

endpackage

// File: rtl/irq_src_gate.sv
module irq_src_gate
    import uart_irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0] raw_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] gated_o,
    output logic         any_o
);
    for (genvar k = 0; k < N; k++) begin : g_gate
        assign gated_o[k] = raw_i[k] & en_i[k];
    end
    assign any_o = |gated_o;
endmodule

// File: rtl/irq_thre_req.sv
module irq_thre_req (
    input  logic clk,
    input  logic rst,
    input  logic empty_i,
    input  logic en_i,
    input  logic hold_wr_i,
    input  logic ident_rd_i,
    input  logic reported_i,
    output logic req_o
);
    logic arm_q;
    logic req_q;
    logic arm;
    logic set_evt;

    assign arm     = empty_i & en_i;
    assign set_evt = arm & ~arm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q <= 1'b0;
            req_q <= 1'b0;
        end else begin
            arm_q <= arm;
            if (hold_wr_i)
                req_q <= 1'b0;
            else if (set_evt)
                req_q <= 1'b1;
            else if (ident_rd_i && reported_i)
                req_q <= 1'b0;
        end
    end

    assign req_o = req_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import uart_irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0] gated_i,
    input  logic         any_i,
    input  logic         timeout_only_i,
    input  logic         fifo_mode_i,
    output ident_t       ident_o
);
    always_comb begin
        ident_o          = '0;
        ident_o.fifo_tag = {2{fifo_mode_i}};
        ident_o.idle     = ~any_i;
        if (any_i) begin
            ident_o.id      = pick_id(gated_i);
            ident_o.timeout = (pick_id(gated_i) == ID_RXD) & timeout_only_i;
        end
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       line_err_i,
    input  logic       rx_avail_i,
    input  logic       rx_timeout_i,
    input  logic       tx_empty_i,
    input  logic       modem_chg_i,
    input  logic [3:0] irq_en_i,
    input  logic       fifo_mode_i,
    input  logic       ident_rd_i,
    input  logic       hold_wr_i,
    output logic       irq_o,
    output logic [7:0] ident_o
);
    logic [NUM_SRC-1:0] raw;
    logic [NUM_SRC-1:0] gated;
    logic               any_pend;
    logic               txe_req;
    logic               to_eff;
    ident_t             ident;

    assign to_eff = rx_timeout_i & fifo_mode_i;

    assign raw[EN_RX]    = rx_avail_i | to_eff;
    assign raw[EN_TXE]   = txe_req;
    assign raw[EN_LINE]  = line_err_i;
    assign raw[EN_MODEM] = modem_chg_i;

    irq_thre_req u_txe (
        .clk        (clk),
        .rst        (rst),
        .empty_i    (tx_empty_i),
        .en_i       (irq_en_i[EN_TXE]),
        .hold_wr_i  (hold_wr_i),
        .ident_rd_i (ident_rd_i),
        .reported_i (!ident.idle && ident.id == ID_TXE),
        .req_o      (txe_req)
    );

    irq_src_gate #(.N(NUM_SRC)) u_gate (
        .raw_i   (raw),
        .en_i    (irq_en_i),
        .gated_o (gated),
        .any_o   (any_pend)
    );

    irq_prio_enc #(.N(NUM_SRC)) u_enc (
        .gated_i        (gated),
        .any_i          (any_pend),
        .timeout_only_i (to_eff & ~rx_avail_i),
        .fifo_mode_i    (fifo_mode_i),
        .ident_o        (ident)
    );

    assign irq_o   = any_pend;
    assign ident_o = ident;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst,
    input logic       line_err_i,
    input logic       tx_empty_i,
    input logic [3:0] irq_en_i,
    input logic       fifo_mode_i,
    input logic       ident_rd_i,
    input logic       hold_wr_i,
    input logic       irq_o,
    input logic [7:0] ident_o
);
    AST_ALL_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (irq_en_i == 4'h0) |-> !irq_o); // R1

    AST_PIN_MATCHES_CODE: assert property (@(posedge clk) disable iff (rst)
        irq_o == !ident_o[0]); // R2

    AST_IDLE_CODE: assert property (@(posedge clk) disable iff (rst)
        ident_o[0] |-> (ident_o[3:1] == 3'b000)); // R3

    AST_LINE_WINS: assert property (@(posedge clk) disable iff (rst)
        (line_err_i && irq_en_i[2]) |-> (ident_o[3:0] == 4'b0110)); // R4

    AST_NONFIFO_BITS: assert property (@(posedge clk) disable iff (rst)
        !fifo_mode_i |-> (ident_o[7:6] == 2'b00 && !ident_o[3])); // R6

    AST_FIFO_TAG: assert property (@(posedge clk) disable iff (rst)
        fifo_mode_i |-> (ident_o[7:6] == 2'b11 && ident_o[5:4] == 2'b00)); // R6

    AST_WR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        hold_wr_i |=> (ident_o[3:0] != 4'b0010)); // R8

    AST_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ident_rd_i && ident_o[3:0] == 4'b0010 && $stable(tx_empty_i)
         && $stable(irq_en_i[1])) |=> (ident_o[3:0] != 4'b0010)); // R9
endmodule

bind uart_irq_ident uart_irq_ident_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .line_err_i  (line_err_i),
    .tx_empty_i  (tx_empty_i),
    .irq_en_i    (irq_en_i),
    .fifo_mode_i (fifo_mode_i),
    .ident_rd_i  (ident_rd_i),
    .hold_wr_i   (hold_wr_i),
    .irq_o       (irq_o),
    .ident_o     (ident_o)
);

// File: tb/uart_irq_ident_tb_top.sv
module uart_irq_ident_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       line_err_i, rx_avail_i, rx_timeout_i, tx_empty_i, modem_chg_i;
    logic [3:0] irq_en_i;
    logic       fifo_mode_i, ident_rd_i, hold_wr_i;
    logic       irq_o;
    logic [7:0] ident_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    uart_irq_ident dut_i (.*);

    // vector: {line, rx, timeout, modem, en[3:0], fifo, exp_ident[7:0], exp_irq}
    localparam int NV = 13;
    localparam logic [17:0] VEC [NV] = '{
        {4'b0000, 4'hF, 1'b0, 8'h01, 1'b0},  // R3 idle
        {4'b1000, 4'hF, 1'b0, 8'h06, 1'b1},  // R4 line
        {4'b1101, 4'hF, 1'b0, 8'h06, 1'b1},  // R4 line over rx, modem
        {4'b0101, 4'hF, 1'b0, 8'h04, 1'b1},  // R4 rx over modem
        {4'b0001, 4'hF, 1'b0, 8'h00, 1'b1},  // R4 modem, R2
        {4'b1100, 4'hB, 1'b0, 8'h04, 1'b1},  // R1 line hidden
        {4'b0001, 4'h7, 1'b0, 8'h01, 1'b0},  // R1 modem hidden, R2
        {4'b0010, 4'hF, 1'b1, 8'hCC, 1'b1},  // R5 timeout alone
        {4'b0010, 4'hF, 1'b0, 8'h01, 1'b0},  // R5 timeout ignored
        {4'b0110, 4'hF, 1'b1, 8'hC4, 1'b1},  // R5 data and timeout
        {4'b0000, 4'hF, 1'b1, 8'hC1, 1'b0},  // R6 fifo idle
        {4'b1111, 4'h0, 1'b1, 8'hC1, 1'b0},  // R1 all disabled
        {4'b0001, 4'hF, 1'b1, 8'hC0, 1'b1}   // R6 modem in fifo
    };

    task automatic check(input string req, input logic [7:0] exp_id, input logic exp_irq);
        checks++;
        if (ident_o !== exp_id || irq_o !== exp_irq) begin
            failures++;
            $display("FAIL %s: ident=%h irq=%b expected ident=%h irq=%b",
                     req, ident_o, irq_o, exp_id, exp_irq);
        end
    endtask

    task automatic pulse_rd();
        @(negedge clk); ident_rd_i = 1'b1;
        @(posedge clk); #1 ident_rd_i = 1'b0;
        #2;
    endtask

    task automatic pulse_wr();
        @(negedge clk); hold_wr_i = 1'b1;
        @(posedge clk); #1 hold_wr_i = 1'b0;
        #2;
    endtask

    task automatic tick();
        @(posedge clk); #2;
    endtask

    initial begin
        rst = 1'b1;
        {line_err_i, rx_avail_i, rx_timeout_i, tx_empty_i, modem_chg_i} = '0;
        irq_en_i = 4'h0; fifo_mode_i = 1'b0; ident_rd_i = 1'b0; hold_wr_i = 1'b0;
        repeat (3) @(posedge clk);
        #2 check("R10 reset", 8'h01, 1'b0);
        @(negedge clk); rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {line_err_i, rx_avail_i, rx_timeout_i, modem_chg_i} = VEC[i][17:14];
            irq_en_i    = VEC[i][13:10];
            fifo_mode_i = VEC[i][9];
            #2 check($sformatf("vector %0d R1-table", i), VEC[i][8:1], VEC[i][0]);
        end

        // R7 rising empty sets request
        @(negedge clk);
        {line_err_i, rx_avail_i, rx_timeout_i, modem_chg_i} = '0;
        fifo_mode_i = 1'b0; irq_en_i = 4'h2; tx_empty_i = 1'b1;
        #2 check("R7 not before edge", 8'h01, 1'b0);
        tick();
        check("R7 set", 8'h02, 1'b1);

        // R9 read while line reported keeps request
        @(negedge clk); irq_en_i = 4'h6; line_err_i = 1'b1;
        #2 check("R4 line over txe", 8'h06, 1'b1);
        pulse_rd();
        @(negedge clk); line_err_i = 1'b0;
        #2 check("R9 read of other source ignored", 8'h02, 1'b1);

        // R9 read while txe reported clears
        pulse_rd();
        check("R9 read clears", 8'h01, 1'b0);
        tick();
        check("R7 no re-set while level held", 8'h01, 1'b0);

        // R7 enable rise while empty sets
        @(negedge clk); irq_en_i = 4'h0;
        tick();
        @(negedge clk); irq_en_i = 4'h2;
        tick();
        check("R7 enable rise sets", 8'h02, 1'b1);

        // R8 holding write clears
        pulse_wr();
        check("R8 write clears", 8'h01, 1'b0);

        // R8 write wins over simultaneous set
        @(negedge clk); tx_empty_i = 1'b0;
        tick();
        @(negedge clk); tx_empty_i = 1'b1; hold_wr_i = 1'b1;
        @(posedge clk); #1 hold_wr_i = 1'b0;
        #2 check("R8 write beats set", 8'h01, 1'b0);

        // R6 txe in fifo mode, R1 hidden when disabled
        @(negedge clk); tx_empty_i = 1'b0;
        tick();
        @(negedge clk); tx_empty_i = 1'b1; fifo_mode_i = 1'b1;
        tick();
        check("R6 txe fifo", 8'hC2, 1'b1);
        @(negedge clk); irq_en_i = 4'hD;
        #2 check("R1 txe hidden", 8'hC1, 1'b0);

        // R10 reset clears held request
        @(negedge clk); irq_en_i = 4'h2; rst = 1'b1;
        tick();
        check("R10 reset clears request", 8'hC1, 1'b0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule